// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register holding the outcomes of the most recent resolved branches, with 1 for taken and 0 for not taken. It combines that history with low bits of the branch address to select one 2-bit saturating counter in a pattern table. A static parameter picks how the two are combined. In concatenation mode the address bits and the history bits are placed side by side. With 4 address bits and 2 history bits, each address gets four counters, one for each recent-outcome context. In XOR mode the address bits and the history are exclusive-ORed, which spreads branches over a smaller table.

The lookup side is purely combinational. A fetch PC on `lookupPc` yields `predTaken` in the same cycle, read from the counter chosen by the live history `curHist`. The front end keeps `curHist` alongside the branch. When the branch resolves, the front end presents the PC, the real outcome and that saved history on the update port. The counter that produced the prediction is then adjusted, and the outcome is shifted into the history. The table has no address tags, so branches that map to the same entry share its counter.

Top module: `ghist_predictor`

## Requirements
- R1: After reset every counter holds weakly not-taken (binary 01) and the history register is zero, so every lookup predicts not taken until an update arrives.
- R2: `predTaken` is the upper bit of the selected counter. With the encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken, states 10 and 11 predict taken. With no update and an unchanged `lookupPc`, the prediction does not change.
- R3: A taken update adds one to the selected counter and stops at 11. A not-taken update subtracts one and stops at 00.
- R4: Each cycle with `updValid` high shifts the history left by one bit. `updTaken` enters at bit 0 and the oldest bit is lost. Without `updValid` the history holds its value.
- R5: In concatenation mode (`IDX_MODE` = IDX_CONCAT) the table index is {PC bits, history}. The PC field is `lookupPc[PC_LSB +: ADDR_BITS]` in the upper part and the history is in the lower part. One PC therefore reaches a different counter for each history value.
- R6: In XOR mode (`IDX_MODE` = IDX_XOR) the table index is the same PC field XORed with the history. Both are zero-extended to the wider of the two.
- R7: An update selects its counter from `updPc` and `updHist`, not from the live history. No other counter changes.
- R8: No address tag is compared. Two PCs that differ only outside the indexed PC field share one counter.
- R9: When a lookup and an update select the same counter in one cycle, the lookup returns the value the counter held before that update.
- R10: `curHist` always presents the current history register. Lookups are indexed with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_W | Fetch PC to predict |
| predTaken | output | 1 | 1 = predicted taken |
| curHist | output | HIST_BITS | Live global history, saved by the front end for the later update |
| updValid | input | 1 | A conditional branch has resolved this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updHist | input | HIST_BITS | History value that was used when this branch was looked up |

## Verification
The assertions assume that reset is held low for at least one clock before it is released. They also assume the update inputs carry known values whenever `updValid` is high. The prediction-stability property further assumes that the table changes only through the update port. The stimulus raises reset only after several cycles and drives every input at the falling edge. It gives `updHist` either the history seen at lookup or a deliberately stale value, so that updates resolved with an old history are also covered.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

  typedef enum logic [0:0] {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idx_mode_e;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic ctrWe;     // write the selected counter
    logic ctrUp;     // 1 = count toward taken
    logic histShift; // shift history
    logic histBit;   // bit shifted in
  } strobe_t;

  function automatic ctr_t satStep(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/ghp_ctrl.sv
module ghp_ctrl
  import ghp_pkg::*;
#(
  parameter int        PC_W      = 32,
  parameter int        PC_LSB    = 2,
  parameter int        ADDR_BITS = 4,
  parameter int        HIST_BITS = 2,
  parameter idx_mode_e IDX_MODE  = IDX_CONCAT,
  parameter int        IDX_W     = ADDR_BITS + HIST_BITS
) (
  input  logic [PC_W-1:0]      lookupPc,
  input  logic [HIST_BITS-1:0] curHist,
  input  logic                 updValid,
  input  logic [PC_W-1:0]      updPc,
  input  logic                 updTaken,
  input  logic [HIST_BITS-1:0] updHist,
  output logic [IDX_W-1:0]     rdIdx,
  output logic [IDX_W-1:0]     wrIdx,
  output strobe_t              strobe
);

  logic [ADDR_BITS-1:0] lkPcBits;
  logic [ADDR_BITS-1:0] upPcBits;
  logic                 unusedPcBits;

  assign lkPcBits     = lookupPc[PC_LSB +: ADDR_BITS];
  assign upPcBits     = updPc[PC_LSB +: ADDR_BITS];
  assign unusedPcBits = ^{lookupPc, updPc};

  generate
    if (IDX_MODE == IDX_CONCAT) begin : g_concat
      assign rdIdx = {lkPcBits, curHist};
      assign wrIdx = {upPcBits, updHist};
    end else begin : g_xor
      assign rdIdx = IDX_W'(lkPcBits) ^ IDX_W'(curHist);
      assign wrIdx = IDX_W'(upPcBits) ^ IDX_W'(updHist);
    end
  endgenerate

  always_comb begin
    strobe.ctrWe     = updValid;
    strobe.ctrUp     = updTaken;
    strobe.histShift = updValid;
    strobe.histBit   = updTaken;
  end

endmodule

// File: rtl/ghp_datapath.sv
module ghp_datapath
  import ghp_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int IDX_W     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDX_W-1:0]     rdIdx,
  input  logic [IDX_W-1:0]     wrIdx,
  input  strobe_t              strobe,
  output ctr_t                 rdCtr,
  output logic [HIST_BITS-1:0] histQ
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t patTable [DEPTH];

  // Combinational read: returns the value before any same-cycle write
  assign rdCtr = patTable[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) patTable[i] <= CTR_WEAK_NT;
    end else if (strobe.ctrWe) begin
      patTable[wrIdx] <= satStep(patTable[wrIdx], strobe.ctrUp);
    end
  end

  generate
    if (HIST_BITS == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (!rstN)                 histQ <= '0;
        else if (strobe.histShift) histQ <= strobe.histBit;
      end
    end else begin : g_histN
      always_ff @(posedge clk) begin
        if (!rstN)                 histQ <= '0;
        else if (strobe.histShift) histQ <= {histQ[HIST_BITS-2:0], strobe.histBit};
      end
    end
  endgenerate

endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor
  import ghp_pkg::*;
#(
  parameter int        PC_W      = 32,
  parameter int        PC_LSB    = 2,
  parameter int        ADDR_BITS = 4,
  parameter int        HIST_BITS = 2,
  parameter idx_mode_e IDX_MODE  = IDX_CONCAT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      lookupPc,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] curHist,
  input  logic                 updValid,
  input  logic [PC_W-1:0]      updPc,
  input  logic                 updTaken,
  input  logic [HIST_BITS-1:0] updHist
);

  localparam int WIDER = (ADDR_BITS > HIST_BITS) ? ADDR_BITS : HIST_BITS;
  localparam int IDX_W = (IDX_MODE == IDX_CONCAT) ? ADDR_BITS + HIST_BITS : WIDER;

  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  strobe_t          strobe;
  ctr_t             rdCtr;

  ghp_ctrl #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .ADDR_BITS(ADDR_BITS),
    .HIST_BITS(HIST_BITS), .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
  ) ctrl_i (
    .lookupPc(lookupPc), .curHist(curHist), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updHist(updHist),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .strobe(strobe)
  );

  ghp_datapath #(
    .HIST_BITS(HIST_BITS), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .rdIdx(rdIdx), .wrIdx(wrIdx),
    .strobe(strobe), .rdCtr(rdCtr), .histQ(curHist)
  );

  assign predTaken = rdCtr[1];

endmodule

// File: rtl/ghp_checker.sv
module ghp_checker #(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [PC_W-1:0]      lookupPc,
  input logic                 predTaken,
  input logic [HIST_BITS-1:0] curHist,
  input logic                 updValid,
  input logic                 updTaken
);

  // R1: history is zero on the first cycle out of reset
  assert_reset_hist_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> curHist == '0);

  // R4: a resolved branch shifts its outcome in at bit 0
  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> curHist == HIST_BITS'({$past(curHist), $past(updTaken)}));

  // R4: the history holds without a resolution
  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(curHist));

  // R2: the same PC with no update in between keeps its prediction
  assert_pred_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lookupPc == $past(lookupPc)) && !$past(updValid) |-> predTaken == $past(predTaken));

endmodule

bind ghist_predictor ghp_checker #(.PC_W(PC_W), .HIST_BITS(HIST_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
  .curHist(curHist), .updValid(updValid), .updTaken(updTaken)
);

// File: tb/ghist_predictor_tb.sv
module ghist_predictor_tb_top;
  import ghp_pkg::*;

  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] lookupPc = '0;
  logic          updValid = 1'b0;
  logic [PW-1:0] updPc = '0;
  logic          updTaken = 1'b0;
  logic [1:0]    updHist = '0;
  logic          predC, predX;
  logic [1:0]    histC, histX;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Model state: counters as integers, history as integer
  int cntC [64];
  int cntX [16];
  int histM;

  always #5 clk = ~clk;

  ghist_predictor #(.PC_W(PW), .PC_LSB(2), .ADDR_BITS(4), .HIST_BITS(2),
                    .IDX_MODE(IDX_CONCAT)) dut_i (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predC),
    .curHist(histC), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updHist(updHist));

  ghist_predictor #(.PC_W(PW), .PC_LSB(2), .ADDR_BITS(4), .HIST_BITS(2),
                    .IDX_MODE(IDX_XOR)) dutx_i (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predX),
    .curHist(histX), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updHist(updHist));

  function automatic int pcField(input logic [PW-1:0] pc);
    return (int'(pc) >> 2) & 15;
  endfunction
  function automatic int idxC(input logic [PW-1:0] pc, input int h);
    return pcField(pc) * 4 + h;
  endfunction
  function automatic int idxX(input logic [PW-1:0] pc, input int h);
    return pcField(pc) ^ h;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare both instances against the model, then advance one clock
  task automatic step(input string tag);
    int eC, eX, wc, wx;
    #1;
    eC = cntC[idxC(lookupPc, histM)] >= 2;
    eX = cntX[idxX(lookupPc, histM)] >= 2;
    chk(predC == eC, {tag, " concat pred R5"}, predC, eC);
    chk(predX == eX, {tag, " xor pred R6"}, predX, eX);
    chk(histC == histM && histX == histM, {tag, " history R10"}, histC, histM);
    @(posedge clk);
    if (updValid) begin
      wc = idxC(updPc, updHist);
      wx = idxX(updPc, updHist);
      if (updTaken) begin
        if (cntC[wc] < 3) cntC[wc]++;
        if (cntX[wx] < 3) cntX[wx]++;
      end else begin
        if (cntC[wc] > 0) cntC[wc]--;
        if (cntX[wx] > 0) cntX[wx]--;
      end
      histM = ((histM << 1) | int'(updTaken)) & 3;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [PW-1:0] lpc, input bit uv,
                       input logic [PW-1:0] upc, input bit ut, input int uh);
    lookupPc = lpc; updValid = uv; updPc = upc; updTaken = ut; updHist = 2'(uh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (cntC[i]) cntC[i] = 1;
    foreach (cntX[i]) cntX[i] = 1;
    histM = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, lookups only
    for (int p = 0; p < 8; p++) begin
      drive(16'(p * 4), 0, '0, 0, 0);
      #1;
      chk(predC == 1'b0 && predX == 1'b0, "R1 reset predicts not taken", predC, 0);
      step("R1");
    end
    chk(histC == 2'b00, "R1 history zero", histC, 0);

    // R3/R7: two taken updates at pc 0x44 with saved history 0
    drive(16'h0044, 1, 16'h0044, 1, 0); step("R3");
    drive(16'h0044, 1, 16'h0044, 1, 0); step("R3");
    #1;
    chk(histC == 2'b11, "R4 two taken shifted in", histC, 3);
    chk(predC == 1'b0, "R5 other context counter untouched", predC, 0);
    // R7: not-taken updates on pc 0x88 with stale history 3 bring history back to 0
    drive(16'h0044, 1, 16'h0088, 0, 3); step("R7");
    drive(16'h0044, 1, 16'h0088, 0, 3); step("R7");
    drive(16'h0044, 0, '0, 0, 0);
    #1;
    chk(histC == 2'b00, "R4 zeros shifted in", histC, 0);
    chk(predC == 1'b1, "R3 counter reached strong taken", predC, 1);
    chk(predX == 1'b0, "R6 xor entry shared and decremented", predX, 0);
    step("R7");
    // R8: alias pc 0x84 shares pc field 1
    drive(16'h0084, 0, '0, 0, 0);
    #1;
    chk(predC == 1'b1, "R8 aliased pc shares counter", predC, 1);
    step("R8");
    // R9: same-cycle lookup and update at one entry
    drive(16'h0044, 1, 16'h0044, 0, 0);
    #1;
    chk(predC == 1'b1, "R9 pre-update value from 11", predC, 1);
    step("R9");
    drive(16'h0044, 1, 16'h0044, 0, 0);
    #1;
    chk(predC == 1'b1, "R9 pre-update value from 10", predC, 1);
    step("R9");
    drive(16'h0044, 0, '0, 0, 0);
    #1;
    chk(predC == 1'b0, "R3 down to weak not-taken", predC, 0);
    step("R3");
    // R3: saturation at both ends
    for (int k = 0; k < 5; k++) begin drive(16'h0010, 1, 16'h0010, 0, 0); step("R3"); end
    for (int k = 0; k < 6; k++) begin drive(16'h0010, 1, 16'h0010, 1, 0); step("R3"); end
    drive(16'h0010, 1, 16'h0010, 0, 0); step("R3");

    // Mixed traffic, history fresh or stale
    for (int n = 0; n < 400; n++) begin
      logic [PW-1:0] lp, up;
      bit uv, ut;
      int uh;
      lp = 16'($urandom_range(0, 127));
      up = 16'($urandom_range(0, 127));
      uv = ($urandom_range(0, 3) != 0);
      ut = ($urandom_range(0, 2) != 0);
      uh = ($urandom_range(0, 1) != 0) ? histM : int'($urandom_range(0, 3));
      if (n % 7 == 0) up = lp;
      drive(lp, uv, up, ut, uh);
      step("R2");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule